// File: doc/BRIEF.md
# Narrow-Write Lane-Aligning AXI Master

This block turns a simple one-word command into a single-beat transaction on a 128-bit AXI master port. A command carries a byte address, a 32-bit value, a transfer size code and a start pulse. For a write, the block moves the value onto the byte lanes of the wide data bus that the address picks, and it shifts the strobe by the same amount. The target register therefore receives the real data and not the zeros that sit in the low lanes.

The write address and write data channels are raised in the same cycle and each drops as soon as its own handshake completes. Once both have completed, the block accepts the write response and reports it with a one-cycle done pulse that carries the 2-bit response code. A read command issues one read beat and returns the 32-bit word held in the lane group that address bits [3:2] select. A new command is taken only while the block is idle.

Top module: `axi_narrow_lane_master`

## Requirements
- R1: While rst_n is low and after its release, m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready and done are all 0 until a command is accepted.
- R2: Every request uses length 0, burst type 0 (fixed), lock 0, cache 0 and protection 0. The address is cmd_addr with its low size bits cleared, and m_awsize/m_arsize equal the effective size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes).
- R3: Write data lanes: with byte offset off = aligned address bits [3:0] and n = 2^size bytes, byte b of cmd_wdata (b < n) appears on m_wdata bits [8*(off+b)+7 : 8*(off+b)]. All other bits are 0 and m_wlast is 1. For example, a 4-byte write to offset 0x4 puts the value in bits [63:32].
- R4: m_wstrb has exactly n ones, at bits off to off+n-1. A 4-byte write gives 0x000F, 0x00F0, 0x0F00 or 0xF000 at offsets 0x0, 0x4, 0x8 or 0xC.
- R5: A raised valid on the AW, W or AR channel stays high with stable payload until its ready is seen, and it drops in the cycle after the handshake.
- R6: An accepted write raises m_awvalid and m_wvalid together in the cycle after the start pulse. Neither waits for the other's handshake.
- R7: m_bready is high only after both the AW and W handshakes have completed, and it stays high until the response handshake. done pulses in the cycle after that handshake, with done_resp equal to the m_bresp received.
- R8: A read raises m_arvalid in the cycle after start, and m_rready rises after the AR handshake. done pulses in the cycle after the R handshake, with done_rdata = m_rdata[32*k+31 : 32*k] where k = address bits [3:2], and done_resp equal to m_rresp.
- R9: A start pulse that arrives while a transaction is in progress is ignored: no second request is issued. done is high for exactly one cycle per transaction.
- R10: Size code 3 asks for more than the 32-bit word, so it is treated as size code 2 (4 bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start pulse, taken only when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 32 | Byte address |
| cmd_size | input | 2 | Size code, log2 of the byte count |
| cmd_wdata | input | 32 | Write value, least significant byte first |
| done | output | 1 | One-cycle completion pulse |
| done_resp | output | 2 | Response code of the completed transaction |
| done_rdata | output | 32 | Read word (valid with done on a read) |
| m_awaddr | output | 32 | Write address |
| m_awlen | output | 8 | Write burst length (always 0) |
| m_awsize | output | 3 | Write size code |
| m_awburst | output | 2 | Write burst type (fixed) |
| m_awlock | output | 1 | Write lock (0) |
| m_awcache | output | 4 | Write cache attributes (0) |
| m_awprot | output | 3 | Write protection (0) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 128 | Lane-aligned write data |
| m_wstrb | output | 16 | Byte-lane strobes |
| m_wlast | output | 1 | Last beat (always 1) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read address |
| m_arlen | output | 8 | Read burst length (always 0) |
| m_arsize | output | 3 | Read size code |
| m_arburst | output | 2 | Read burst type (fixed) |
| m_arlock | output | 1 | Read lock (0) |
| m_arcache | output | 4 | Read cache attributes (0) |
| m_arprot | output | 3 | Read protection (0) |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 128 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
Writes are swept over all 16 byte offsets and all four size codes. The sweep separates correct lane placement from a shift of the strobe alone, and correct alignment masking from passing unaligned low address bits through. Each write is repeated under rotating AW/W ready orders (address first, data first, both together) and response delays. These runs tell a master that waits on the wrong handshake apart from one that waits on both, and they check that each response code reaches done_resp. Reads use a different word in each lane group, with garbage on the bus outside the valid cycle, so that a wrong lane choice or a wrong capture cycle shows up. Starts that arrive mid-transaction check that no second request follows.

// File: rtl/axi_nlm_pkg.sv
// Shared types and fixed bus attribute codes for the narrow lane-aligning master.
package axi_nlm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREQ,
        ST_WRESP,
        ST_RREQ,
        ST_RDATA
    } nlm_state_e;

    localparam logic [7:0] LEN_SINGLE  = 8'd0;
    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic       LOCK_NORMAL = 1'b0;
    localparam logic [3:0] CACHE_NONE  = 4'b0000;
    localparam logic [2:0] PROT_PLAIN  = 3'b000;
endpackage

// File: rtl/nlm_lane_packer.sv
// Lane packer: clamps the size code to the word, aligns the byte offset to that
// size and places the kept bytes of the word, and their strobes, on the lanes.
// Assumes BUS_W and WORD_W are powers of two with WORD_W <= BUS_W.
module nlm_lane_packer #(
    parameter int BUS_W  = 128,
    parameter int WORD_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic [$clog2(BUS_W/8)-1:0] byte_addr,
    input  logic [SIZE_W-1:0]          size_req,
    input  logic [WORD_W-1:0]          word_in,
    output logic [SIZE_W-1:0]          size_eff,
    output logic [$clog2(BUS_W/8)-1:0] lane_off,
    output logic [BUS_W-1:0]           lane_data,
    output logic [BUS_W/8-1:0]         lane_strb
);
    localparam int STRB_W     = BUS_W / 8;
    localparam int OFF_W      = $clog2(STRB_W);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int MAX_CODE   = $clog2(WORD_BYTES);

    logic [WORD_BYTES-1:0] byte_keep;
    logic [WORD_W-1:0]     word_kept;

    // Clamp the size code and clear the offset bits below the transfer size.
    always_comb begin
        size_eff = (size_req > SIZE_W'(MAX_CODE)) ? SIZE_W'(MAX_CODE) : size_req;
        lane_off = byte_addr & ~((OFF_W'(1) << size_eff) - OFF_W'(1));
    end

    // One keep flag per word byte: byte b is kept when b < 2^size.
    genvar b;
    generate
        for (b = 0; b < WORD_BYTES; b++) begin : g_keep
            assign byte_keep[b]           = ((32'(b) >> size_eff) == 32'd0);
            assign word_kept[b*8 +: 8]    = byte_keep[b] ? word_in[b*8 +: 8] : 8'h00;
        end
    endgenerate

    // Shift data and strobe together by the aligned offset.
    always_comb begin
        lane_data = BUS_W'(word_kept) << {lane_off, 3'b000};
        lane_strb = STRB_W'(byte_keep) << lane_off;
    end
endmodule

// File: rtl/nlm_lane_picker.sv
// Lane picker: returns the word-sized lane group selected by sel from the bus.
// Assumes BUS_W / WORD_W is a power of two.
module nlm_lane_picker #(
    parameter int BUS_W  = 128,
    parameter int WORD_W = 32
) (
    input  logic [BUS_W-1:0]                   bus_in,
    input  logic [$clog2(BUS_W/WORD_W)-1:0]    sel,
    output logic [WORD_W-1:0]                  word_out
);
    localparam int WORDS = BUS_W / WORD_W;

    logic [WORD_W-1:0] groups [WORDS];

    genvar g;
    generate
        for (g = 0; g < WORDS; g++) begin : g_split
            assign groups[g] = bus_in[g*WORD_W +: WORD_W];
        end
    endgenerate

    // Select the addressed lane group.
    assign word_out = groups[sel];
endmodule

// File: rtl/nlm_txn_ctl.sv
// Transaction controller: sequences one write (AW and W in parallel, then B)
// or one read (AR then R), and produces the done pulse with the response code
// and the captured read word. Assumes the slave follows the AXI handshake rules.
module nlm_txn_ctl
    import axi_nlm_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic              awready,
    input  logic              wready,
    input  logic              bvalid,
    input  logic [1:0]        bresp,
    input  logic              arready,
    input  logic              rvalid,
    input  logic [1:0]        rresp,
    input  logic [WORD_W-1:0] picked_word,
    output logic              accept,
    output logic              awvalid,
    output logic              wvalid,
    output logic              bready,
    output logic              arvalid,
    output logic              rready,
    output logic              done,
    output logic [1:0]        done_resp,
    output logic [WORD_W-1:0] done_rdata
);
    nlm_state_e state;
    logic       aw_pend;
    logic       w_pend;
    logic       b_hs;
    logic       r_hs;

    // Handshake and accept decodes.
    always_comb begin
        accept = start && (state == ST_IDLE);
        b_hs   = (state == ST_WRESP) && bvalid;
        r_hs   = (state == ST_RDATA) && rvalid;
    end

    // Channel control outputs.
    always_comb begin
        awvalid = aw_pend;
        wvalid  = w_pend;
        bready  = (state == ST_WRESP);
        arvalid = (state == ST_RREQ);
        rready  = (state == ST_RDATA);
    end

    // State register and per-channel pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            aw_pend <= 1'b0;
            w_pend  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept && is_write) begin
                        state   <= ST_WREQ;
                        aw_pend <= 1'b1;
                        w_pend  <= 1'b1;
                    end else if (accept) begin
                        state <= ST_RREQ;
                    end
                end
                ST_WREQ: begin
                    if (aw_pend && awready) aw_pend <= 1'b0;
                    if (w_pend && wready)   w_pend  <= 1'b0;
                    if ((!aw_pend || awready) && (!w_pend || wready)) state <= ST_WRESP;
                end
                ST_WRESP: if (bvalid)  state <= ST_IDLE;
                ST_RREQ:  if (arready) state <= ST_RDATA;
                ST_RDATA: if (rvalid)  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse, response code and captured read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            done_resp  <= 2'b00;
            done_rdata <= '0;
        end else begin
            done <= b_hs || r_hs;
            if (b_hs) done_resp <= bresp;
            if (r_hs) begin
                done_resp  <= rresp;
                done_rdata <= picked_word;
            end
        end
    end
endmodule

// File: rtl/axi_narrow_lane_master.sv
// Narrow-write lane-aligning AXI master (top). Latches a command while idle,
// presents it as one single-beat request with lane-aligned data and strobes,
// and reports completion. Assumes ADDR_W covers the bus byte offset bits.
module axi_narrow_lane_master
    import axi_nlm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 128,
    parameter int WORD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_start,
    input  logic                 cmd_write,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [1:0]           cmd_size,
    input  logic [WORD_W-1:0]    cmd_wdata,
    output logic                 done,
    output logic [1:0]           done_resp,
    output logic [WORD_W-1:0]    done_rdata,
    output logic [ADDR_W-1:0]    m_awaddr,
    output logic [7:0]           m_awlen,
    output logic [2:0]           m_awsize,
    output logic [1:0]           m_awburst,
    output logic                 m_awlock,
    output logic [3:0]           m_awcache,
    output logic [2:0]           m_awprot,
    output logic                 m_awvalid,
    input  logic                 m_awready,
    output logic [BUS_W-1:0]     m_wdata,
    output logic [BUS_W/8-1:0]   m_wstrb,
    output logic                 m_wlast,
    output logic                 m_wvalid,
    input  logic                 m_wready,
    input  logic [1:0]           m_bresp,
    input  logic                 m_bvalid,
    output logic                 m_bready,
    output logic [ADDR_W-1:0]    m_araddr,
    output logic [7:0]           m_arlen,
    output logic [2:0]           m_arsize,
    output logic [1:0]           m_arburst,
    output logic                 m_arlock,
    output logic [3:0]           m_arcache,
    output logic [2:0]           m_arprot,
    output logic                 m_arvalid,
    input  logic                 m_arready,
    input  logic [BUS_W-1:0]     m_rdata,
    input  logic [1:0]           m_rresp,
    input  logic                 m_rvalid,
    output logic                 m_rready
);
    localparam int STRB_W = BUS_W / 8;
    localparam int OFF_W  = $clog2(STRB_W);
    localparam int SEL_W  = $clog2(BUS_W / WORD_W);
    localparam int WSEL_L = $clog2(WORD_W / 8);

    logic [1:0]        size_eff;
    logic [OFF_W-1:0]  lane_off;
    logic [BUS_W-1:0]  lane_data;
    logic [STRB_W-1:0] lane_strb;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [BUS_W-1:0]  data_q;
    logic [STRB_W-1:0] strb_q;
    logic [WORD_W-1:0] picked_word;

    nlm_lane_packer #(.BUS_W(BUS_W), .WORD_W(WORD_W), .SIZE_W(2)) u_packer (
        .byte_addr (cmd_addr[OFF_W-1:0]),
        .size_req  (cmd_size),
        .word_in   (cmd_wdata),
        .size_eff  (size_eff),
        .lane_off  (lane_off),
        .lane_data (lane_data),
        .lane_strb (lane_strb)
    );

    nlm_lane_picker #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_picker (
        .bus_in   (m_rdata),
        .sel      (addr_q[WSEL_L +: SEL_W]),
        .word_out (picked_word)
    );

    nlm_txn_ctl #(.WORD_W(WORD_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cmd_start),
        .is_write    (cmd_write),
        .awready     (m_awready),
        .wready      (m_wready),
        .bvalid      (m_bvalid),
        .bresp       (m_bresp),
        .arready     (m_arready),
        .rvalid      (m_rvalid),
        .rresp       (m_rresp),
        .picked_word (picked_word),
        .accept      (accept),
        .awvalid     (m_awvalid),
        .wvalid      (m_wvalid),
        .bready      (m_bready),
        .arvalid     (m_arvalid),
        .rready      (m_rready),
        .done        (done),
        .done_resp   (done_resp),
        .done_rdata  (done_rdata)
    );

    // Command latch: holds the aligned address and packed lanes for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= 2'b00;
            data_q <= '0;
            strb_q <= '0;
        end else if (accept) begin
            addr_q <= {cmd_addr[ADDR_W-1:OFF_W], lane_off};
            size_q <= size_eff;
            data_q <= lane_data;
            strb_q <= lane_strb;
        end
    end

    // Request payloads with fixed single-beat attributes.
    always_comb begin
        m_awaddr  = addr_q;
        m_awlen   = LEN_SINGLE;
        m_awsize  = {1'b0, size_q};
        m_awburst = BURST_FIXED;
        m_awlock  = LOCK_NORMAL;
        m_awcache = CACHE_NONE;
        m_awprot  = PROT_PLAIN;
        m_wdata   = data_q;
        m_wstrb   = strb_q;
        m_wlast   = 1'b1;
        m_araddr  = addr_q;
        m_arlen   = LEN_SINGLE;
        m_arsize  = {1'b0, size_q};
        m_arburst = BURST_FIXED;
        m_arlock  = LOCK_NORMAL;
        m_arcache = CACHE_NONE;
        m_arprot  = PROT_PLAIN;
    end
endmodule

// File: rtl/nlm_checker.sv
// Protocol checker for the narrow lane-aligning master, bound to the top module.
module nlm_checker #(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 128
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    m_awaddr,
    input logic [7:0]           m_awlen,
    input logic [2:0]           m_awsize,
    input logic [1:0]           m_awburst,
    input logic                 m_awvalid,
    input logic                 m_awready,
    input logic [BUS_W-1:0]     m_wdata,
    input logic [BUS_W/8-1:0]   m_wstrb,
    input logic                 m_wlast,
    input logic                 m_wvalid,
    input logic                 m_wready,
    input logic                 m_bvalid,
    input logic                 m_bready,
    input logic [ADDR_W-1:0]    m_araddr,
    input logic                 m_arvalid,
    input logic                 m_arready,
    input logic                 m_rvalid,
    input logic                 m_rready,
    input logic                 done
);
    // R5: address valid holds with a stable address until accepted
    assert_aw_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    // R5: data valid holds with stable data and strobes until accepted
    assert_w_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wstrb)));

    // R5: read address valid holds with a stable address until accepted
    assert_ar_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    // R4: strobe count matches the announced size
    assert_strb_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && m_awvalid) |-> ($countones(m_wstrb) == (32'd1 << m_awsize)));

    // R2: single fixed beat on every write request
    assert_single_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awlen == 8'd0 && m_awburst == 2'b00 && m_wlast));

    // R7: response is accepted only after both request handshakes
    assert_bready_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_bready |-> (!m_awvalid && !m_wvalid));

    // R7, R8: done follows a response handshake
    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past((m_bvalid && m_bready) || (m_rvalid && m_rready)));

    // R9: done is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: never a read and a write in flight together
    assert_one_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_awvalid || m_wvalid || m_bready, m_arvalid || m_rready}));
endmodule

bind axi_narrow_lane_master nlm_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/axi_narrow_lane_master_bench.sv
// Sweep bench: all offsets and size codes for writes, all offsets for reads,
// rotating handshake orders, with expected lanes computed per byte.
module axi_narrow_lane_master_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_start = 1'b0;
    logic         cmd_write = 1'b0;
    logic [31:0]  cmd_addr = '0;
    logic [1:0]   cmd_size = '0;
    logic [31:0]  cmd_wdata = '0;
    logic         done;
    logic [1:0]   done_resp;
    logic [31:0]  done_rdata;
    logic [31:0]  m_awaddr;
    logic [7:0]   m_awlen;
    logic [2:0]   m_awsize;
    logic [1:0]   m_awburst;
    logic         m_awlock;
    logic [3:0]   m_awcache;
    logic [2:0]   m_awprot;
    logic         m_awvalid;
    logic         m_awready = 1'b0;
    logic [127:0] m_wdata;
    logic [15:0]  m_wstrb;
    logic         m_wlast;
    logic         m_wvalid;
    logic         m_wready = 1'b0;
    logic [1:0]   m_bresp = '0;
    logic         m_bvalid = 1'b0;
    logic         m_bready;
    logic [31:0]  m_araddr;
    logic [7:0]   m_arlen;
    logic [2:0]   m_arsize;
    logic [1:0]   m_arburst;
    logic         m_arlock;
    logic [3:0]   m_arcache;
    logic [2:0]   m_arprot;
    logic         m_arvalid;
    logic         m_arready = 1'b0;
    logic [127:0] m_rdata = '0;
    logic [1:0]   m_rresp = '0;
    logic         m_rvalid = 1'b0;
    logic         m_rready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    axi_narrow_lane_master u_axi_narrow_lane_master (.*);

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One write: awd/wd/bd are the ready/response delays in cycles; poke sends a stray start.
    task automatic do_write(input logic [31:0] addr, input logic [1:0] sz, input logic [31:0] data,
                            input int awd, input int wd, input int bd, input logic [1:0] resp,
                            input bit poke);
        int sz_e = (sz == 2'd3) ? 2 : int'(sz);
        int nb = 1 << sz_e;
        int off = int'(addr[3:0]) & ~(nb - 1);
        logic [31:0]  exp_addr = addr & ~32'(nb - 1);
        logic [127:0] exp_data = '0;
        logic [15:0]  exp_strb = '0;
        int m_d = (awd > wd) ? awd : wd;
        int t = m_d + 1 + bd;
        for (int b = 0; b < 16; b++) begin
            if (b >= off && b < off + nb) begin
                exp_data[b*8 +: 8] = data[(b-off)*8 +: 8];
                exp_strb[b] = 1'b1;
            end
        end
        @(negedge clk);
        cmd_write = 1'b1; cmd_addr = addr; cmd_size = sz; cmd_wdata = data; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int c = 0; c <= t + 2; c++) begin
            chk(m_awvalid == (c <= awd), (c == 0) ? "R6 awvalid" : "R5 awvalid", 128'(m_awvalid), 128'(c <= awd));
            chk(m_wvalid == (c <= wd), (c == 0) ? "R6 wvalid" : "R5 wvalid", 128'(m_wvalid), 128'(c <= wd));
            if (c <= awd) begin
                chk(m_awaddr == exp_addr, "R2 awaddr", 128'(m_awaddr), 128'(exp_addr));
                chk(m_awsize == 3'(sz_e), "R10 awsize", 128'(m_awsize), 128'(sz_e));
            end
            if (c == 0) begin
                chk({m_awlen, m_awburst, m_awlock, m_awcache, m_awprot} == '0, "R2 attrs",
                    128'({m_awlen, m_awburst, m_awlock, m_awcache, m_awprot}), 128'(0));
            end
            if (c <= wd) begin
                chk(m_wdata == exp_data, "R3 wdata", m_wdata, exp_data);
                chk(m_wstrb == exp_strb, "R4 wstrb", 128'(m_wstrb), 128'(exp_strb));
                chk(m_wlast == 1'b1, "R3 wlast", 128'(m_wlast), 128'(1));
            end
            chk(m_bready == (c > m_d && c <= t), "R7 bready", 128'(m_bready), 128'(c > m_d && c <= t));
            chk(done == (c == t + 1), "R9 done pulse", 128'(done), 128'(c == t + 1));
            chk(m_arvalid == 1'b0, "R9 no stray read", 128'(m_arvalid), 128'(0));
            if (c == t + 1) chk(done_resp == resp, "R7 done_resp", 128'(done_resp), 128'(resp));
            m_awready = (c == awd);
            m_wready  = (c == wd);
            m_bvalid  = (c == t);
            m_bresp   = (c == t) ? resp : ~resp;
            cmd_start = poke && (c == 0 || c == t);
            cmd_write = 1'b0;
            cmd_addr  = 32'h0000_0F00;
            @(negedge clk);
        end
        m_awready = 1'b0; m_wready = 1'b0; m_bvalid = 1'b0; cmd_start = 1'b0;
    endtask

    // One read: ard/rd are the address-ready and data delays in cycles.
    task automatic do_read(input logic [31:0] addr, input int ard, input int rd, input logic [1:0] resp,
                           input logic [127:0] pat);
        int t = ard + 1 + rd;
        logic [31:0] exp_word = pat[32*int'(addr[3:2]) +: 32];
        @(negedge clk);
        cmd_write = 1'b0; cmd_addr = addr; cmd_size = 2'd2; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int c = 0; c <= t + 2; c++) begin
            chk(m_arvalid == (c <= ard), "R8 arvalid", 128'(m_arvalid), 128'(c <= ard));
            if (c <= ard) chk(m_araddr == {addr[31:2], 2'b00}, "R2 araddr", 128'(m_araddr), 128'({addr[31:2], 2'b00}));
            chk(m_rready == (c > ard && c <= t), "R8 rready", 128'(m_rready), 128'(c > ard && c <= t));
            chk(m_awvalid == 1'b0, "R9 no write", 128'(m_awvalid), 128'(0));
            chk(done == (c == t + 1), "R8 done", 128'(done), 128'(c == t + 1));
            if (c == t + 1) begin
                chk(done_rdata == exp_word, "R8 rdata lane", 128'(done_rdata), 128'(exp_word));
                chk(done_resp == resp, "R8 rresp", 128'(done_resp), 128'(resp));
            end
            m_arready = (c == ard);
            m_rvalid  = (c == t);
            m_rdata   = (c == t) ? pat : ~pat;
            m_rresp   = (c == t) ? resp : ~resp;
            @(negedge clk);
        end
        m_arready = 1'b0; m_rvalid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, done} == '0, "R1 in reset",
            128'({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, done}), 128'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, done} == '0, "R1 after reset",
            128'({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, done}), 128'(0));
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 16; o++) begin
                int i = s * 16 + o;
                do_write(32'hA000_1000 + 32'(o), 2'(s), 32'h8765_4321 ^ (32'(i) * 32'h0101_0101),
                         i % 3, (i / 3) % 3, i % 2, 2'(i % 4), (i % 5) == 0);
            end
        end
        for (int o = 0; o < 16; o++) begin
            do_read(32'hB000_0040 + 32'(o), o % 3, (o / 2) % 3, 2'(o % 4),
                    {32'hDDDD_0000 + 32'(o), 32'hCCCC_0000 + 32'(o), 32'hBBBB_0000 + 32'(o), 32'hAAAA_0000 + 32'(o)});
        end
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end
endmodule